// File: doc/BRIEF.md
# Receiver message-ignore gating unit

This unit sits between the symbol decoder of a serial-bus receiver and the host register interface. It holds an ignore flag that the host can write. While the flag is set, the receiver is muted: the status flags presented to the host are held at zero, and the rest of the frame in flight is thrown away. Every interrupt source is also suppressed, except one dedicated source code, `0x20`.

The flag clears itself when the decoder reports a start-of-frame or a break symbol, so the next frame is received normally. The host can also clear the flag by writing 0. All outputs are registered. A result appears on the clock edge that samples the stimulus causing it.

Top module: `rx_ignore_gate`

## Requirements
- R1: After reset, `ignore_o` is 0, `status_o` is all zeros, `src_o` is `0x00` and `irq_o` is 0.
- R2: A host write (`host_wr`=1) loads `host_wdata` into the ignore flag. The new value shows on `ignore_o` after the next clock edge, so writing 0 clears the flag at once.
- R3: Whenever `ignore_o` is 1, `status_o` is all zeros.
- R4: Raw status and raw source codes presented in the same cycle as a host write of 1 are already discarded. The outputs after that edge show zero status, and show a source code of `0x00` unless that code is `0x20`.
- R5: A `sof_pulse` or `brk_pulse` with no host write in the same cycle clears the ignore flag at the next edge.
- R6: A host write of 1 in the same cycle as `sof_pulse` or `brk_pulse` leaves the flag set.
- R7: While muted, `src_o` reports `0x00` for every raw code except `0x20`, which is reported unchanged.
- R8: `irq_o` is 1 exactly when `gie` was 1 and the reported source code is non-zero. This applies to the `0x20` source while muted as well.
- R9: While not muted, `status_o` and `src_o` equal `raw_status` and `raw_src` from the cycle before.
- R10: The raw inputs present in the cycle of the clearing symbol are not recorded. Status is all zeros on the edge where `ignore_o` falls; tracking resumes one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the ignore flag |
| host_wdata | input | 1 | Value written to the ignore flag |
| sof_pulse | input | 1 | One-cycle start-of-frame detected |
| brk_pulse | input | 1 | One-cycle break symbol detected |
| raw_status | input | NSTAT | Unfiltered status flags from the receiver |
| raw_src | input | 8 | Unfiltered interrupt source code, 0 = none |
| gie | input | 1 | Global interrupt enable |
| status_o | output | NSTAT | Status flags visible to the host |
| ignore_o | output | 1 | Read-back of the ignore flag |
| irq_o | output | 1 | Interrupt request |
| src_o | output | 8 | Reported interrupt source code |

## Verification
Every output is one register away from the inputs. The ignore flag, the status flags, the source code and the request therefore all change on the first rising edge after the stimulus is driven. The bench drives inputs on the falling edge. It computes each expected value from the model flag held before that edge, then samples one time unit after the rising edge. At that point all four results are due together, and none has been overwritten by the next stimulus. The clearing-cycle rule (R10) is checked on the same edge where the flag reads back 0.

// File: rtl/rxig_pkg.sv
package rxig_pkg;
  localparam int unsigned CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t KEEP_CODE = code_t'(8'h20);

  // next value of the ignore flag; a host write has priority over symbols
  function automatic logic f_flag_next(input logic cur, input logic wr,
                                       input logic wd, input logic sof,
                                       input logic brk);
    if (wr)              return wd;
    else if (sof || brk) return 1'b0;
    else                 return cur;
  endfunction

  // source code as reported to the host under the current mute state
  function automatic code_t f_pass_code(input code_t code, input logic mute);
    if (!mute)              return code;
    if (code == KEEP_CODE)  return code;
    return '0;
  endfunction
endpackage

// File: rtl/rxig_flag.sv
module rxig_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic host_wr,
  input  logic host_wdata,
  input  logic sof_pulse,
  input  logic brk_pulse,
  output logic flag_q,
  output logic mute
);
  import rxig_pkg::*;

  logic set_evt;
  logic clr_evt;

  assign set_evt = host_wr && host_wdata;
  assign clr_evt = !host_wr && (sof_pulse || brk_pulse);
  // muted when already ignoring or when the flag is being set this cycle
  assign mute    = flag_q || set_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= f_flag_next(flag_q, host_wr, host_wdata,
                                      sof_pulse, brk_pulse);
  end

  p_symbol_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !flag_q);
  p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && (sof_pulse || brk_pulse)) |=> flag_q);
  p_write_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_wdata) |=> !flag_q);
endmodule

// File: rtl/rxig_status.sv
module rxig_status #(
  parameter int unsigned NSTAT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mute,
  input  logic             flag_q,
  input  logic [NSTAT-1:0] raw_status,
  output logic [NSTAT-1:0] status_q
);
  for (genvar i = 0; i < NSTAT; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= raw_status[i] && !mute;
    end
  end

  p_held_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |-> (status_q == '0));
  p_tracks_raw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mute |=> (status_q == $past(raw_status)));
  p_clear_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> (status_q == '0));
endmodule

// File: rtl/rxig_irq.sv
module rxig_irq (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mute,
  input  logic                 gie,
  input  rxig_pkg::code_t      raw_src,
  output rxig_pkg::code_t      src_q,
  output logic                 irq_q
);
  import rxig_pkg::*;

  code_t src_d;
  assign src_d = f_pass_code(raw_src, mute);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      irq_q <= 1'b0;
    end else begin
      src_q <= src_d;
      irq_q <= gie && (src_d != '0);
    end
  end

  p_mask_others_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mute && raw_src != KEEP_CODE) |=> (src_q == '0) && !irq_q);
  p_keep_passes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_src == KEEP_CODE) |=> (src_q == KEEP_CODE));
  p_gie_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> !irq_q);
  p_req_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (src_q != '0));
endmodule

// File: rtl/rx_ignore_gate.sv
module rx_ignore_gate #(
  parameter int unsigned NSTAT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_wdata,
  input  logic             sof_pulse,
  input  logic             brk_pulse,
  input  logic [NSTAT-1:0] raw_status,
  input  logic [7:0]       raw_src,
  input  logic             gie,
  output logic [NSTAT-1:0] status_o,
  output logic             ignore_o,
  output logic             irq_o,
  output logic [7:0]       src_o
);
  import rxig_pkg::*;

  logic  flag_q;
  logic  mute;
  code_t src_q;

  rxig_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .sof_pulse  (sof_pulse),
    .brk_pulse  (brk_pulse),
    .flag_q     (flag_q),
    .mute       (mute)
  );

  rxig_status #(.NSTAT(NSTAT)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .mute       (mute),
    .flag_q     (flag_q),
    .raw_status (raw_status),
    .status_q   (status_o)
  );

  rxig_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mute    (mute),
    .gie     (gie),
    .raw_src (code_t'(raw_src)),
    .src_q   (src_q),
    .irq_q   (irq_o)
  );

  assign ignore_o = flag_q;
  assign src_o    = src_q;

  // R4: a set write drops that cycle's inputs at once
  p_set_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_wdata) |=> (status_o == '0) && ignore_o);
endmodule

// File: tb/rx_ignore_gate_tb_top.sv
`timescale 1ns/1ps
module rx_ignore_gate_tb_top;
  localparam int NST = 8;
  localparam logic [7:0] KEEP = 8'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 0, host_wdata = 0, sof_pulse = 0, brk_pulse = 0, gie = 0;
  logic [NST-1:0] raw_status = '0;
  logic [7:0] raw_src = '0;
  logic [NST-1:0] status_o;
  logic ignore_o, irq_o;
  logic [7:0] src_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic m_ign = 0;

  always #2.5 clk = ~clk;

  rx_ignore_gate #(.NSTAT(NST)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .sof_pulse(sof_pulse), .brk_pulse(brk_pulse), .raw_status(raw_status),
    .raw_src(raw_src), .gie(gie), .status_o(status_o), .ignore_o(ignore_o),
    .irq_o(irq_o), .src_o(src_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // bench restatement of the reported code
  function automatic logic [7:0] exp_code(input logic [7:0] c, input logic silent);
    return (silent && c != KEEP) ? 8'h00 : c;
  endfunction

  task automatic step(input logic wr, input logic wd, input logic sof,
                      input logic brk, input logic [NST-1:0] st,
                      input logic [7:0] sc, input logic g);
    logic silent, nxt;
    logic [7:0] ec;
    string st_tag, ig_tag;
    @(negedge clk);
    host_wr = wr; host_wdata = wd; sof_pulse = sof; brk_pulse = brk;
    raw_status = st; raw_src = sc; gie = g;
    silent = m_ign | (wr & wd);
    nxt = wr ? wd : ((sof | brk) ? 1'b0 : m_ign);
    ec = exp_code(sc, silent);
    if (wr && (sof || brk)) ig_tag = "R6";
    else if (!wr && (sof || brk)) ig_tag = "R5";
    else ig_tag = "R2";
    if (m_ign && !nxt) st_tag = "R10";
    else if (!m_ign && wr && wd) st_tag = "R4";
    else if (silent) st_tag = "R3";
    else st_tag = "R9";
    @(posedge clk); #1;
    chk(ig_tag, ignore_o, nxt);
    chk(st_tag, status_o, silent ? '0 : st);
    chk(silent ? "R7" : "R9", src_o, ec);
    chk("R8", irq_o, g && ec != 0);
    m_ign = nxt;
  endtask

  function automatic logic [7:0] pick_src();
    case ($urandom % 4)
      0: return 8'h00;
      1: return KEEP;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", ignore_o, 0); chk("R1", status_o, 0);
    chk("R1", src_o, 0);    chk("R1", irq_o, 0);
    @(negedge clk); rst_n = 1;
    // directed: tracking, then set mid-frame
    step(0,0,0,0, 8'hA5, 8'h11, 1);
    step(1,1,0,0, 8'hFF, 8'h33, 1);   // R4: set drops this cycle
    step(0,0,0,0, 8'h3C, 8'h44, 1);   // R7: masked
    step(0,0,0,0, 8'h3C, KEEP, 1);    // R7/R8: 0x20 passes
    step(0,0,0,0, 8'h3C, KEEP, 0);    // R8: gie gates it
    step(1,1,1,0, 8'h01, 8'h05, 1);   // R6: write beats sof
    step(1,1,0,1, 8'h01, 8'h05, 1);   // R6: write beats break
    step(0,0,1,0, 8'h77, 8'h66, 1);   // R10: clearing cycle dropped
    step(0,0,0,0, 8'h5A, 8'h66, 1);   // R9: tracking resumes
    step(1,1,0,0, 8'h00, 8'h00, 1);
    step(0,0,0,1, 8'h81, 8'h09, 1);   // R5: break clears
    step(1,1,0,0, 8'h00, 8'h00, 1);
    step(1,0,0,0, 8'h42, 8'h07, 1);   // R2: write 0 clears
    step(0,0,0,0, 8'h42, 8'h07, 0);   // R8: gie low
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic wr;
      wr = ($urandom % 6) == 0;
      step(wr, 1'($urandom), ($urandom % 7) == 0, ($urandom % 11) == 0,
           NST'($urandom), pick_src(), ($urandom % 4) != 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule